// File: doc/BRIEF.md
# Coherent Memory Bus Responder

This block is the memory side of a split-transaction cache-coherent bus. It watches request packets, keeps a small block-organised memory, and builds the reply packets that the caches wait for. Read-block, word-write and conditional-word-write requests depend on how the caches answered the snoop. For these the block samples the bus-shared and bus-owner wires two cycles after the request header. It then decides whether to reply at all and how to set the reply's shared flag.

Every request passes through a fixed three-stage pipeline: header capture, memory read, then snoop sampling and reply build. Replies enter a small first-in first-out queue that drives the bus arbiter's high-priority port. Write-block and flush-block data reaches memory on the header edge. A read-block issued on the very next cycle therefore already sees the new data. Reply packets that appear on the bus are ignored.

Top module: `mem_bus_responder`

## Requirements
- R1: After synchronous reset the reply queue is empty and `rpl_valid` is low.
- R2: Command codes are 4 bits wide. Requests use even codes: read-block 0, word-write 2, conditional-word-write 4, write-block 6, flush-block 8, demap 10. The matching reply is the request code plus one. A packet with bit 0 set is a reply: it produces no reply and leaves memory unchanged.
- R3: A read-block header accepted in cycle t samples `bus_shared`/`bus_owner` in cycle t+2. If `bus_owner` is low, a reply with code 1 appears at the queue head in cycle t+3. It carries the addressed block's stored data and `shared` equal to the sampled `bus_shared`.
- R4: A read-block whose sampled `bus_owner` is high produces no reply.
- R5: A write-block stores the full block into memory at block index `req_addr[AW-1:3]`. It replies with code 7, `shared` 0 and zero data, whatever `bus_shared` is.
- R6: A flush-block stores the block in the same way. It replies with code 9, `shared` 0 and zero data.
- R7: A word-write replies with code 3, the request's address and data, and `shared` equal to `bus_shared` sampled in cycle t+2. Memory is not changed.
- R8: A conditional-word-write replies like a word-write but with code 5. The reply also carries the request's old value on `rpl_old`.
- R9: A demap replies with code 11, the request address, `shared` 0 and zero data.
- R10: Every reply carries the requester ID of the request that caused it.
- R11: Replies leave the queue in the order their requests arrived. Raising `rpl_pop` while `rpl_valid` is high removes the head.
- R12: A read-block to a block written by a write-block one cycle earlier returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A packet header is on the bus this cycle |
| req_cmd | input | 4 | Packet command code |
| req_id | input | IDW | Requester ID |
| req_addr | input | AW | Word address |
| req_data | input | WORDS*DW | Block data (write/flush); word in low DW bits for word writes |
| req_old | input | DW | Old value of a conditional word write |
| bus_shared | input | 1 | Wired-OR shared answer from the caches |
| bus_owner | input | 1 | Wired-OR owner answer from the caches |
| rpl_pop | input | 1 | Remove the queue head |
| rpl_valid | output | 1 | Queue holds a reply |
| rpl_cmd | output | 4 | Reply command code |
| rpl_id | output | IDW | Requester ID echoed |
| rpl_shared | output | 1 | Reply shared flag |
| rpl_addr | output | AW | Reply address |
| rpl_data | output | WORDS*DW | Reply data |
| rpl_old | output | DW | Old value (conditional word write) |

## Verification
Two things can fall into the same cycle. A write-block header writes memory on the same edge at which the previous header's memory read is taken. A read-block issued one cycle after a write-block to the same block must then see the new contents. The bench issues these two packets back to back, releases the second one's snoop sample with shared high, and pops both replies. It judges order and contents: the write reply must come first, and the read reply must carry the fresh block and the shared flag.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [3:0] {
    CMD_RD_REQ = 4'd0,  CMD_RD_RPL = 4'd1,
    CMD_WW_REQ = 4'd2,  CMD_WW_RPL = 4'd3,
    CMD_CW_REQ = 4'd4,  CMD_CW_RPL = 4'd5,
    CMD_WB_REQ = 4'd6,  CMD_WB_RPL = 4'd7,
    CMD_FB_REQ = 4'd8,  CMD_FB_RPL = 4'd9,
    CMD_DM_REQ = 4'd10, CMD_DM_RPL = 4'd11
  } bus_cmd_e;
  localparam int CMD_W = 4;
endpackage

// File: rtl/mbr_block_mem.sv
module mbr_block_mem #(
  parameter int BW   = 256,
  parameter int NBLK = 32,
  localparam int IW  = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [BW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [BW-1:0] rdata
);
  logic [BW-1:0] store [NBLK];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/mbr_reply_queue.sv
module mbr_reply_queue #(
  parameter int PW    = 64,
  parameter int DEPTH = 4,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [PW-1:0] push_pkt,
  input  logic          pop,
  output logic          head_valid,
  output logic [PW-1:0] head_pkt
);
  logic [PW-1:0] slots [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [PTRW:0]   count;
  logic            do_pop;

  assign do_pop     = pop && (count != '0);
  assign head_valid = (count != '0);
  assign head_pkt   = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_pkt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != (PTRW+1)'(DEPTH)) || pop); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)
             || (count + 1'b1 == $past(count))); // R11
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !push) |=> (count == '0)); // R11
endmodule

// File: rtl/mbr_reply_build.sv
module mbr_reply_build
  import mbr_pkg::*;
#(
  parameter int IDW = 4,
  parameter int AW  = 8,
  parameter int BW  = 256,
  parameter int DW  = 32
) (
  input  logic             valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [IDW-1:0]   id,
  input  logic [AW-1:0]    addr,
  input  logic [BW-1:0]    req_data,
  input  logic [DW-1:0]    req_old,
  input  logic [BW-1:0]    mem_rdata,
  input  logic             bus_shared,
  input  logic             bus_owner,
  output logic             push,
  output logic [CMD_W-1:0] o_cmd,
  output logic [IDW-1:0]   o_id,
  output logic             o_shared,
  output logic [AW-1:0]    o_addr,
  output logic [BW-1:0]    o_data,
  output logic [DW-1:0]    o_old
);
  always_comb begin
    push     = 1'b0;
    o_cmd    = {cmd[CMD_W-1:1], 1'b1};
    o_id     = id;
    o_addr   = addr;
    o_shared = 1'b0;
    o_data   = '0;
    o_old    = '0;
    if (valid) begin
      case (cmd)
        CMD_RD_REQ: begin
          push     = !bus_owner;
          o_shared = bus_shared;
          o_data   = mem_rdata;
        end
        CMD_WW_REQ: begin
          push     = 1'b1;
          o_shared = bus_shared;
          o_data   = req_data;
        end
        CMD_CW_REQ: begin
          push     = 1'b1;
          o_shared = bus_shared;
          o_data   = req_data;
          o_old    = req_old;
        end
        CMD_WB_REQ, CMD_FB_REQ, CMD_DM_REQ: push = 1'b1;
        default: push = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mem_bus_responder.sv
module mem_bus_responder
  import mbr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WORDS  = 8,
  parameter int AW     = 8,
  parameter int IDW    = 4,
  parameter int QDEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [3:0]          req_cmd,
  input  logic [IDW-1:0]      req_id,
  input  logic [AW-1:0]       req_addr,
  input  logic [WORDS*DW-1:0] req_data,
  input  logic [DW-1:0]       req_old,
  input  logic                bus_shared,
  input  logic                bus_owner,
  input  logic                rpl_pop,
  output logic                rpl_valid,
  output logic [3:0]          rpl_cmd,
  output logic [IDW-1:0]      rpl_id,
  output logic                rpl_shared,
  output logic [AW-1:0]       rpl_addr,
  output logic [WORDS*DW-1:0] rpl_data,
  output logic [DW-1:0]       rpl_old
);
  localparam int BW   = WORDS * DW;
  localparam int OFFW = $clog2(WORDS);
  localparam int IW   = AW - OFFW;
  localparam int NBLK = 1 << IW;
  localparam int PW   = CMD_W + IDW + 1 + AW + BW + DW;

  // stage 1: header captured; stage 2: memory data present, snoop sampled
  logic             s1_valid, s2_valid;
  logic [CMD_W-1:0] s1_cmd, s2_cmd;
  logic [IDW-1:0]   s1_id, s2_id;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [BW-1:0]    s1_data, s2_data, s2_rdata, mem_q;
  logic [DW-1:0]    s1_old, s2_old;
  logic             mem_we;

  assign mem_we = req_valid && !req_cmd[0]
                  && (req_cmd == CMD_WB_REQ || req_cmd == CMD_FB_REQ);

  mbr_block_mem #(.BW(BW), .NBLK(NBLK)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (req_addr[AW-1:OFFW]),
    .wdata (req_data),
    .raddr (req_addr[AW-1:OFFW]),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      s1_valid <= req_valid && !req_cmd[0];
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_cmd   <= req_cmd;
    s1_id    <= req_id;
    s1_addr  <= req_addr;
    s1_data  <= req_data;
    s1_old   <= req_old;
    s2_cmd   <= s1_cmd;
    s2_id    <= s1_id;
    s2_addr  <= s1_addr;
    s2_data  <= s1_data;
    s2_old   <= s1_old;
    s2_rdata <= mem_q;
  end

  logic             q_push, q_shared;
  logic [CMD_W-1:0] q_cmd;
  logic [IDW-1:0]   q_id;
  logic [AW-1:0]    q_addr;
  logic [BW-1:0]    q_data;
  logic [DW-1:0]    q_old;

  mbr_reply_build #(.IDW(IDW), .AW(AW), .BW(BW), .DW(DW)) u_build (
    .valid      (s2_valid),
    .cmd        (s2_cmd),
    .id         (s2_id),
    .addr       (s2_addr),
    .req_data   (s2_data),
    .req_old    (s2_old),
    .mem_rdata  (s2_rdata),
    .bus_shared (bus_shared),
    .bus_owner  (bus_owner),
    .push       (q_push),
    .o_cmd      (q_cmd),
    .o_id       (q_id),
    .o_shared   (q_shared),
    .o_addr     (q_addr),
    .o_data     (q_data),
    .o_old      (q_old)
  );

  logic [PW-1:0] head;

  mbr_reply_queue #(.PW(PW), .DEPTH(QDEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (q_push),
    .push_pkt   ({q_cmd, q_id, q_shared, q_addr, q_data, q_old}),
    .pop        (rpl_pop),
    .head_valid (rpl_valid),
    .head_pkt   (head)
  );

  assign {rpl_cmd, rpl_id, rpl_shared, rpl_addr, rpl_data, rpl_old} = head;

  AST_REPLY_CODE: assert property (@(posedge clk) disable iff (rst)
    q_push |-> q_cmd[0]); // R2
  AST_OWNED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_cmd == CMD_RD_REQ && bus_owner) |-> !q_push); // R4
  AST_BLOCK_UNSHARED: assert property (@(posedge clk) disable iff (rst)
    (q_push && (q_cmd == CMD_WB_RPL || q_cmd == CMD_FB_RPL)) |-> !q_shared); // R5
  AST_DEMAP_UNSHARED: assert property (@(posedge clk) disable iff (rst)
    (q_push && q_cmd == CMD_DM_RPL) |-> (!q_shared && q_data == '0)); // R9
  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> !rpl_valid); // R1
endmodule

// File: tb/tb_mem_bus_responder.sv
module tb_mem_bus_responder;
  localparam int DW = 32, WORDS = 8, AW = 8, IDW = 4, BW = DW * WORDS;

  logic clk = 0, rst = 1;
  logic req_valid = 0, bus_shared = 0, bus_owner = 0, rpl_pop = 0;
  logic [3:0] req_cmd = 0;
  logic [IDW-1:0] req_id = 0;
  logic [AW-1:0] req_addr = 0;
  logic [BW-1:0] req_data = 0;
  logic [DW-1:0] req_old = 0;
  logic rpl_valid, rpl_shared;
  logic [3:0] rpl_cmd;
  logic [IDW-1:0] rpl_id;
  logic [AW-1:0] rpl_addr;
  logic [BW-1:0] rpl_data;
  logic [DW-1:0] rpl_old;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  mem_bus_responder #(.DW(DW), .WORDS(WORDS), .AW(AW), .IDW(IDW), .QDEPTH(4)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd), .req_id(req_id),
    .req_addr(req_addr), .req_data(req_data), .req_old(req_old),
    .bus_shared(bus_shared), .bus_owner(bus_owner), .rpl_pop(rpl_pop),
    .rpl_valid(rpl_valid), .rpl_cmd(rpl_cmd), .rpl_id(rpl_id), .rpl_shared(rpl_shared),
    .rpl_addr(rpl_addr), .rpl_data(rpl_data), .rpl_old(rpl_old));

  function automatic logic [BW-1:0] pat(int k);
    logic [BW-1:0] v;
    for (int i = 0; i < WORDS; i++) v[i*DW +: DW] = (k * 32'h01010101) ^ (i * 32'h00110011) ^ 32'hA5000000;
    return v;
  endfunction

  task automatic chk(string rq, logic [BW-1:0] got, logic [BW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic drive(logic [3:0] c, logic [IDW-1:0] id, logic [AW-1:0] a,
                       logic [BW-1:0] d, logic [DW-1:0] o);
    req_valid = 1; req_cmd = c; req_id = id; req_addr = a; req_data = d; req_old = o;
  endtask

  // header in cycle t, snoop flags in cycle t+2, return at negedge of cycle t+3
  task automatic send(logic [3:0] c, logic [IDW-1:0] id, logic [AW-1:0] a,
                      logic [BW-1:0] d, logic [DW-1:0] o, logic sh, logic own);
    @(negedge clk) drive(c, id, a, d, o);
    @(negedge clk) req_valid = 0;
    @(negedge clk) begin bus_shared = sh; bus_owner = own; end
    @(negedge clk) begin bus_shared = 0; bus_owner = 0; end
  endtask

  task automatic pop_one;
    rpl_pop = 1;
    @(negedge clk) rpl_pop = 0;
  endtask

  task automatic read_back(string rq, logic [AW-1:0] a, logic [BW-1:0] exp);
    send(4'd0, 4'd1, a, '0, '0, 1'b0, 1'b0);
    chk(rq, rpl_valid, 1);
    chk(rq, rpl_data, exp);
    pop_one();
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", rpl_valid, 0);
  endtask

  task automatic t_write_block;
    send(4'd6, 4'd3, 8'h20, pat(1), '0, 1'b1, 1'b0);
    chk("R5 valid", rpl_valid, 1);
    chk("R5 code", rpl_cmd, 4'd7);
    chk("R5 shared", rpl_shared, 0);
    chk("R5 data", rpl_data, '0);
    chk("R10 id", rpl_id, 4'd3);
    pop_one();
    chk("R11 empty after pop", rpl_valid, 0);
  endtask

  task automatic t_read_block;
    send(4'd0, 4'd5, 8'h23, '0, '0, 1'b1, 1'b0);
    chk("R3 code", rpl_cmd, 4'd1);
    chk("R3 data", rpl_data, pat(1));
    chk("R3 shared high", rpl_shared, 1);
    chk("R10 id", rpl_id, 4'd5);
    chk("R3 addr", rpl_addr, 8'h23);
    pop_one();
    send(4'd0, 4'd6, 8'h20, '0, '0, 1'b0, 1'b0);
    chk("R3 shared low", rpl_shared, 0);
    pop_one();
  endtask

  task automatic t_read_owned;
    send(4'd0, 4'd2, 8'h20, '0, '0, 1'b1, 1'b1);
    chk("R4 no reply", rpl_valid, 0);
    @(negedge clk) chk("R4 still none", rpl_valid, 0);
  endtask

  task automatic t_flush;
    send(4'd8, 4'd4, 8'h28, pat(2), '0, 1'b1, 1'b0);
    chk("R6 code", rpl_cmd, 4'd9);
    chk("R6 shared", rpl_shared, 0);
    chk("R6 data", rpl_data, '0);
    pop_one();
    read_back("R6 stored", 8'h28, pat(2));
  endtask

  task automatic t_word_write;
    send(4'd2, 4'd2, 8'h22, pat(7), '0, 1'b1, 1'b0);
    chk("R7 code", rpl_cmd, 4'd3);
    chk("R7 data", rpl_data, pat(7));
    chk("R7 addr", rpl_addr, 8'h22);
    chk("R7 shared", rpl_shared, 1);
    pop_one();
    read_back("R7 memory unchanged", 8'h20, pat(1));
  endtask

  task automatic t_cond_write;
    send(4'd4, 4'd9, 8'h31, pat(8), 32'hDEAD0001, 1'b0, 1'b0);
    chk("R8 code", rpl_cmd, 4'd5);
    chk("R8 old", rpl_old, 32'hDEAD0001);
    chk("R8 new", rpl_data, pat(8));
    chk("R8 shared", rpl_shared, 0);
    pop_one();
  endtask

  task automatic t_demap;
    send(4'd10, 4'd11, 8'h55, pat(4), '0, 1'b1, 1'b0);
    chk("R9 code", rpl_cmd, 4'd11);
    chk("R9 addr", rpl_addr, 8'h55);
    chk("R9 shared", rpl_shared, 0);
    chk("R9 data", rpl_data, '0);
    pop_one();
  endtask

  task automatic t_replies_ignored;
    send(4'd7, 4'd3, 8'h20, pat(9), '0, 1'b1, 1'b0);
    chk("R2 write reply ignored", rpl_valid, 0);
    send(4'd1, 4'd3, 8'h20, pat(9), '0, 1'b1, 1'b0);
    chk("R2 read reply ignored", rpl_valid, 0);
    read_back("R2 memory untouched", 8'h20, pat(1));
  endtask

  task automatic t_back_to_back;
    @(negedge clk) drive(4'd6, 4'd1, 8'h30, pat(3), '0);
    @(negedge clk) drive(4'd0, 4'd2, 8'h37, '0, '0);
    @(negedge clk) req_valid = 0;
    @(negedge clk) bus_shared = 1;
    @(negedge clk) bus_shared = 0;
    chk("R11 first is write reply", rpl_cmd, 4'd7);
    pop_one();
    chk("R12 read reply present", rpl_valid, 1);
    chk("R12 read code", rpl_cmd, 4'd1);
    chk("R12 fresh data", rpl_data, pat(3));
    chk("R12 shared", rpl_shared, 1);
    pop_one();
  endtask

  task automatic t_order;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk) drive(4'd10, 4'(i), 8'(i), '0, '0);
    end
    @(negedge clk) req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 1; i <= 3; i++) begin
      chk("R11 order id", rpl_id, 4'(i));
      pop_one();
    end
    chk("R11 drained", rpl_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write_block();
    t_read_block();
    t_read_owned();
    t_flush();
    t_word_write();
    t_cond_write();
    t_demap();
    t_replies_ignored();
    t_back_to_back();
    t_order();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule